// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDR SDRAM from its post-power-on state into a usable, programmed state. Once the supply and clock have been stable for the time the memory demands (a wait handled elsewhere), a single start pulse launches a fixed sequence. First CKE is raised. Then one precharge of every bank is issued, followed by eight auto-refresh commands and a mode-register load. The mode word selects CAS latency 2, sequential bursts and a burst length of 8. A few deselect cycles then follow, and a done flag rises.

Every command occupies exactly one clock, and all pins come straight from flops, so each command is settled well before the memory samples it. A parameter sets the number of deselect clocks placed between consecutive commands. The integrator sizes it to cover the precharge, refresh-cycle and mode-load recovery times at the clock rate in use. Once done is high, the block stays quiet and leaves the command pins to normal memory traffic logic, which should use done as its enable.

Top module: `sdram_boot_seq`

## Requirements
- R1: In reset and until a start is accepted, the command pins {cs_n, ras_n, cas_n, we_n} are 4'b1111 (deselect), the address and bank pins are zero, cke is 0 and done is 0.
- R2: A start sampled high while the sequence has never run since reset is accepted, and cke goes to 1 in the next cycle. It stays 1 until reset, and holding start high for several cycles produces only one sequence.
- R3: The first command appears one cycle after cke rises: precharge-all, pins 4'b0010, with address bit 10 high, every other address bit low and bank 0.
- R4: Exactly REFRESH_CNT (default 8) auto-refresh commands, pins 4'b0001 with address and bank zero, follow the precharge-all.
- R5: Between any two consecutive commands there are exactly GAP_CLKS (default 2, minimum 1) deselect cycles (pins 4'b1111, address zero), and each command lasts a single clock.
- R6: The command after the last auto-refresh is load-mode, pins 4'b0000, with bank 0 and address 0x23: bits 2:0 = 3'b011 (burst 8), bit 3 = 0 (sequential), bits 6:4 = 3'b010 (CAS latency 2), higher bits 0.
- R7: After load-mode come exactly TAIL_CLKS (default 2, minimum 2) deselect cycles, and done rises in the following cycle.
- R8: Once high, done stays high until reset, the pins stay deselected, and a further start pulse changes nothing.
- R9: A start pulse while the sequence is running is ignored, and the command stream is unchanged.
- R10: A synchronous reset in the middle of the sequence returns every output to the R1 state in the next cycle, and a later start runs the complete sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the SDRAM clock domain |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the sequence when idle and not yet run |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address, zero throughout |
| sd_addr | output | ADDR_W | Address pins: bit 10 for precharge-all, mode word for load-mode |
| sd_cke | output | 1 | Clock enable to the memory |
| done | output | 1 | Sequence complete, held until reset |

## Verification
The hardest situations to reach from the ports are a start that arrives while the sequence is running or after it has finished, and a reset that cuts the sequence off partway. No normal driver would produce these. The bench pulses start on chosen cycles inside the gap and command phases and again after done. It also holds start high for several clocks and asserts reset in the middle of the refresh run, then launches a fresh sequence. A behavioural model built from queued expected cycles is compared against every pin on every clock, and the logged command order is checked at the end of each completed run.

// File: rtl/sdboot_pkg.sv
package sdboot_pkg;

  // kind of command chosen for the current cycle
  typedef enum logic [1:0] {
    K_NONE,
    K_PRE,
    K_REF,
    K_LMR
  } cmd_kind_t;

  // sequencer phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_GAP,
    ST_TAIL,
    ST_DONE
  } seq_state_t;

  // pin patterns {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_INHIBIT = 4'b1111;
  localparam logic [3:0] PINS_PRE     = 4'b0010;
  localparam logic [3:0] PINS_REF     = 4'b0001;
  localparam logic [3:0] PINS_LMR     = 4'b0000;

  // mode word fields
  localparam logic [2:0] BURST_LEN_8 = 3'b011;
  localparam logic       BURST_SEQ   = 1'b0;
  localparam logic [2:0] CAS_LAT_2   = 3'b010;
  localparam int         MODE_BITS   = 7;
  localparam logic [MODE_BITS-1:0] MODE_WORD = {CAS_LAT_2, BURST_SEQ, BURST_LEN_8};

  function automatic logic [3:0] kind_pins(cmd_kind_t k);
    logic [3:0] p;
    case (k)
      K_PRE:   p = PINS_PRE;
      K_REF:   p = PINS_REF;
      K_LMR:   p = PINS_LMR;
      default: p = PINS_INHIBIT;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sdboot_interval.sv
module sdboot_interval #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  // load_val is at least 1; the wait then lasts load_val cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val - CW'(1);
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdboot_step_ctl.sv
module sdboot_step_ctl
  import sdboot_pkg::*;
#(
  parameter int REFRESH_CNT = 8,
  parameter int GAP_EFF     = 2,
  parameter int TAIL_EFF    = 2,
  parameter int CW          = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          tmr_run,
  output cmd_kind_t     kind,
  output logic          accept,
  output logic          at_done
);

  localparam int SW = $clog2(REFRESH_CNT + 2);
  localparam logic [SW-1:0] LAST_STEP = SW'(REFRESH_CNT + 1);

  seq_state_t      state_q;
  logic [SW-1:0]   step_q;
  logic            last_step;

  assign last_step = (step_q == LAST_STEP);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = CW'(GAP_EFF);
    tmr_run  = 1'b0;
    kind     = K_NONE;
    accept   = 1'b0;
    case (state_q)
      ST_IDLE: accept = start;
      ST_ISSUE: begin
        tmr_load = 1'b1;
        if (step_q == '0) begin
          kind = K_PRE;
        end else if (last_step) begin
          kind    = K_LMR;
          tmr_val = CW'(TAIL_EFF);
        end else begin
          kind = K_REF;
        end
      end
      ST_GAP:  tmr_run = 1'b1;
      ST_TAIL: tmr_run = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_ISSUE;
            step_q  <= '0;
          end
        end
        ST_ISSUE: state_q <= last_step ? ST_TAIL : ST_GAP;
        ST_GAP: begin
          if (tmr_expired) begin
            state_q <= ST_ISSUE;
            step_q  <= step_q + SW'(1);
          end
        end
        ST_TAIL: begin
          if (tmr_expired) state_q <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign at_done = (state_q == ST_DONE);

endmodule

// File: rtl/sdboot_pin_reg.sv
module sdboot_pin_reg
  import sdboot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_kind_t         kind,
  input  logic              accept,
  input  logic              at_done,
  output logic [3:0]        pins,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              cke,
  output logic              done
);

  logic [ADDR_W-1:0] addr_n;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
    if (i == AP_BIT && i < MODE_BITS) begin : g_both
      assign addr_n[i] = (kind == K_PRE) || ((kind == K_LMR) && MODE_WORD[i]);
    end else if (i == AP_BIT) begin : g_ap
      assign addr_n[i] = (kind == K_PRE);
    end else if (i < MODE_BITS) begin : g_mode
      assign addr_n[i] = (kind == K_LMR) && MODE_WORD[i];
    end else begin : g_zero
      assign addr_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins <= PINS_INHIBIT;
      addr <= '0;
      ba   <= '0;
      cke  <= 1'b0;
      done <= 1'b0;
    end else begin
      pins <= kind_pins(kind);
      addr <= addr_n;
      ba   <= '0;
      cke  <= cke | accept;
      done <= at_done;
    end
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdboot_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10,
  parameter int REFRESH_CNT = 8,
  parameter int GAP_CLKS    = 2,
  parameter int TAIL_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_cke,
  output logic              done
);

  localparam int GAP_EFF  = (GAP_CLKS < 1) ? 1 : GAP_CLKS;
  localparam int TAIL_EFF = (TAIL_CLKS < 2) ? 2 : TAIL_CLKS;
  localparam int MAX_WAIT = (GAP_EFF > TAIL_EFF) ? GAP_EFF : TAIL_EFF;
  localparam int CW       = $clog2(MAX_WAIT + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_run;
  logic          tmr_expired;
  cmd_kind_t     kind;
  logic          accept;
  logic          at_done;
  logic [3:0]    pins;

  sdboot_interval #(.CW(CW)) u_interval (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expired  (tmr_expired)
  );

  sdboot_step_ctl #(
    .REFRESH_CNT (REFRESH_CNT),
    .GAP_EFF     (GAP_EFF),
    .TAIL_EFF    (TAIL_EFF),
    .CW          (CW)
  ) u_step (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_run     (tmr_run),
    .kind        (kind),
    .accept      (accept),
    .at_done     (at_done)
  );

  sdboot_pin_reg #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .AP_BIT (AP_BIT)
  ) u_pins (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .accept  (accept),
    .at_done (at_done),
    .pins    (pins),
    .addr    (sd_addr),
    .ba      (sd_ba),
    .cke     (sd_cke),
    .done    (done)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;

endmodule

// File: rtl/sdboot_chk.sv
module sdboot_chk #(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10,
  parameter int REFRESH_CNT = 8,
  parameter int GAP_CLKS    = 2,
  parameter int TAIL_CLKS   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_cke,
  input logic              done
);

  logic [3:0] cmd;
  logic [7:0] ref_seen;
  localparam logic [ADDR_W-1:0] AP_ONLY = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(8'h23);

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  always_ff @(posedge clk) begin
    if (rst) ref_seen <= '0;
    else if (cmd == 4'b0001) ref_seen <= ref_seen + 8'd1;
  end

  // R1: no command is issued before cke is high
  assert_no_cmd_without_cke_R1: assert property (@(posedge clk) disable iff (rst)
    !sd_cke |-> sd_cs_n);

  // R2: cke never drops outside reset
  assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    sd_cke |=> sd_cke);

  // R3: precharge-all carries only the auto-precharge address bit and bank 0
  assert_pre_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> (sd_addr == AP_ONLY && sd_ba == '0));

  // R4: load-mode only after the full refresh count; never too many refreshes
  assert_ref_count_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (ref_seen == 8'(REFRESH_CNT)));
  assert_ref_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0001) |-> (ref_seen < 8'(REFRESH_CNT)));

  // R5: a command is always followed by a deselect cycle
  assert_cmd_one_clock_R5: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |=> sd_cs_n);

  // R6: mode word on the address pins during load-mode
  assert_mode_word_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (sd_addr == MODE_A && sd_ba == '0));

  // R7: done rises only after a deselect cycle
  assert_done_after_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(sd_cs_n));

  // R8: done is sticky, quiet and unaffected by start
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (done || start && done) |=> done);
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd == 4'b1111));

endmodule

bind sdram_boot_seq sdboot_chk #(
  .ADDR_W      (ADDR_W),
  .BA_W        (BA_W),
  .AP_BIT      (AP_BIT),
  .REFRESH_CNT (REFRESH_CNT),
  .GAP_CLKS    (GAP_CLKS),
  .TAIL_CLKS   (TAIL_CLKS)
) u_chk (.*);

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

  localparam int AW = 13;
  localparam int BW = 2;
  localparam int NREF = 8;
  localparam int GAP = 2;
  localparam int TAIL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, done;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  always #5 clk = ~clk;

  sdram_boot_seq #(
    .ADDR_W(AW), .BA_W(BW), .AP_BIT(10), .REFRESH_CNT(NREF),
    .GAP_CLKS(GAP), .TAIL_CLKS(TAIL)
  ) i_sdram_boot_seq (
    .clk(clk), .rst(rst), .start(start),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(addr), .sd_cke(cke), .done(done)
  );

  typedef struct {
    logic [3:0]    cmd;
    logic [AW-1:0] a;
    logic          k;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  logic model_cke = 1'b0;
  logic model_done = 1'b0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [3:0]    log_cmd[$];
  logic [AW-1:0] log_addr[$];

  task automatic push(input logic [3:0] c, input logic [AW-1:0] a, input string t);
    exp_t e;
    e.cmd = c; e.a = a; e.k = 1'b1; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic push_seq();
    push(4'b1111, '0, "R2");
    push(4'b0010, AW'(1) << 10, "R3");
    for (int r = 0; r < NREF; r++) begin
      for (int g = 0; g < GAP; g++) push(4'b1111, '0, "R5");
      push(4'b0001, '0, "R4");
    end
    for (int g = 0; g < GAP; g++) push(4'b1111, '0, "R5");
    push(4'b0000, AW'(8'h23), "R6");
    for (int g = 0; g < TAIL; g++) push(4'b1111, '0, "R7");
    model_cke = 1'b1;
    model_done = 1'b1;
  endtask

  task automatic check_one(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic compare();
    exp_t e;
    logic exp_done;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      exp_done = 1'b0;
    end else begin
      e.cmd = 4'b1111; e.a = '0; e.k = model_cke;
      e.tag = model_done ? "R8" : "R1";
      exp_done = model_done;
    end
    check_one(e.tag, "cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, e.cmd});
    check_one(e.tag, "addr", 32'(addr), 32'(e.a));
    check_one(e.tag, "ba", 32'(ba), 32'd0);
    check_one(e.tag, "cke", {31'd0, cke}, {31'd0, e.k});
    check_one(exp_done ? "R7" : e.tag, "done", {31'd0, done}, {31'd0, exp_done});
    if (!cs_n) begin
      log_cmd.push_back({cs_n, ras_n, cas_n, we_n});
      log_addr.push_back(addr);
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(input logic st, input logic r);
    start = st;
    rst = r;
    if (r) begin
      exp_q.delete();
      model_cke = 1'b0;
      model_done = 1'b0;
      log_cmd.delete();
      log_addr.delete();
    end else if (st && exp_q.size() == 0 && !model_done) begin
      push_seq();
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic check_log(input string when);
    check_one("R4", {when, " cmd count"}, 32'(log_cmd.size()), 32'(NREF + 2));
    if (log_cmd.size() == NREF + 2) begin
      check_one("R3", {when, " first cmd"}, 32'(log_cmd[0]), 32'h2);
      for (int i = 1; i <= NREF; i++)
        check_one("R4", {when, " refresh cmd"}, 32'(log_cmd[i]), 32'h1);
      check_one("R6", {when, " last cmd"}, 32'(log_cmd[NREF + 1]), 32'h0);
      check_one("R6", {when, " mode addr"}, 32'(log_addr[NREF + 1]), 32'h23);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset and idle state
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);

    // full run with stray starts inside it (R9)
    cyc(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) cyc(i == 3 || i == 10 || i == 27, 1'b0);
    check_log("run1");

    // R8: start after done is ignored
    for (int i = 0; i < 12; i++) cyc(i == 2 || i == 5, 1'b0);

    // R10: reset mid-sequence, then a new run with start held high (R2)
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    for (int i = 0; i < 15; i++) cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0);
    check_log("run2");

    finish_run();
  end

endmodule